// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block forms the single trigger line that a timer hands to slave timers or to a converter so that they can start, count or sample in step with it. A three-bit source field, loaded through a write strobe, chooses what drives the line. The choices are the software update strobe, the counter's effective run enable, the counter update event, a pulse on each channel-1 capture/compare event, or one of four compare reference levels. The counter, prescaler, compare logic and register bus sit outside; the block takes their single-cycle strobes and levels as inputs.

The run enable seen by the selector is the control run bit ORed with the slave trigger input when the slave controller gates the counter. A slave trigger normally passes through one resynchronising stage before it reaches the enable. When the master/slave sync input is high, that stage is bypassed, so the trigger line no longer lags behind the slave path. A counter reset caused by the slave trigger also appears on the line in the software-update mode, one cycle later than a software update.

The block also routes one DMA request per channel. A select bit chooses whether a channel's request is raised by that channel's capture/compare event or by the update event. Each request is held until the matching acknowledge arrives.

Top module: `tmr_trig_out_sel`

## Requirements
- R1: While `rst` is high, at each clock edge the source field becomes 0, the DMA select becomes 0, `trig_out` goes low and every `dma_req` bit goes low.
- R2: When `cfg_we` is high at an edge, `cfg_mode` and `cfg_dma_upd` are stored at that edge. The stored field selects the source used at the following edge, and the old field still applies at the edge where the write happens.
- R3: With source field 0 (binary 000), `sw_upd_gen` high in a cycle gives `trig_out` high after the next edge. `slv_reset_evt` high in a cycle gives `trig_out` high after the second edge, not the first.
- R4: With source field 1 (binary 001), `trig_out` after an edge equals `run_bit | (slv_gated & T)` sampled before that edge, where T is the delayed or direct slave trigger of R5. `run_bit` alone reaches `trig_out` after one edge.
- R5: In source field 1 with `slv_gated` high, a `slv_trig` pulse reaches `trig_out` after the second edge when `ms_sync` is 0, and after the first edge when `ms_sync` is 1.
- R6: With source field 2 (binary 010), `upd_evt` high in a cycle gives `trig_out` high after the next edge.
- R7: With source field 3 (binary 011), every cycle with `ch1_cc_evt` high gives a one-cycle high on `trig_out` after the next edge. Events in back-to-back cycles keep the output high in each of those cycles, with no low gap.
- R8: With source field 4, 5, 6 or 7 (binary 100 to 111), `trig_out` after an edge equals `oc_ref[0]`, `oc_ref[1]`, `oc_ref[2]` or `oc_ref[3]` respectively, sampled before that edge.
- R9: With DMA select 0, `cc_evt[i]` raises `dma_req[i]` after the next edge, and `upd_evt` has no effect on requests. With DMA select 1, `upd_evt` raises every `dma_req` bit after the next edge, and `cc_evt` has no effect.
- R10: A raised `dma_req[i]` stays high until an edge with `dma_ack[i]` high and no new request event for channel i. At that edge it goes low. A request event and an acknowledge for the same channel in the same cycle leave the request high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the source field and the DMA select |
| cfg_mode | input | 3 | Trigger source field value to store |
| cfg_dma_upd | input | 1 | DMA select to store: 0 = channel event, 1 = update event |
| ms_sync | input | 1 | Master/slave sync: bypasses the slave trigger delay stage |
| sw_upd_gen | input | 1 | Software update-generation strobe |
| slv_reset_evt | input | 1 | Counter reset caused by the slave trigger in reset mode |
| run_bit | input | 1 | Counter run control bit |
| slv_gated | input | 1 | Slave controller is in gated mode |
| slv_trig | input | 1 | Slave trigger input level |
| upd_evt | input | 1 | Counter update event strobe |
| ch1_cc_evt | input | 1 | Channel-1 capture/compare flag-set strobe |
| oc_ref | input | 4 | Compare reference levels of channels 1 to 4 |
| cc_evt | input | NCH | Per-channel capture/compare event strobes |
| dma_ack | input | NCH | Per-channel DMA acknowledge |
| trig_out | output | 1 | Registered trigger output to slaves |
| dma_req | output | NCH | Per-channel DMA requests, held until acknowledged |

## Verification
Every result appears a fixed number of edges after its stimulus. Most sources, the DMA set and the DMA clear take effect one edge after the input. A slave-caused counter reset, and a slave trigger with `ms_sync` low, take two edges. A configuration write takes effect on the source one edge after the write edge. The bench drives inputs on falling edges and reads outputs on the next falling edge. A behavioural model, updated at each rising edge from the inputs it saw, is compared with both outputs in every cycle. Directed checks count the falling edges explicitly: they confirm that a one-edge result is absent where a two-edge result is expected, and that the old source still holds for the edge at which a write happens.

// File: rtl/tos_pkg.sv
package tos_pkg;

    localparam int MODE_W = 3;
    localparam int NREF   = 4;
    localparam int REF_W  = $clog2(NREF);

    typedef enum logic [MODE_W-1:0] {
        TM_SWUPD = 3'd0,
        TM_RUN   = 3'd1,
        TM_UPD   = 3'd2,
        TM_C1P   = 3'd3,
        TM_REF1  = 3'd4,
        TM_REF2  = 3'd5,
        TM_REF3  = 3'd6,
        TM_REF4  = 3'd7
    } trig_mode_e;

    typedef struct packed {
        trig_mode_e mode;
        logic       dma_on_upd;
    } tos_cfg_t;

    typedef struct packed {
        logic sw_upd;
        logic slv_rst;
        logic run_bit;
        logic gated;
        logic slv_trig;
        logic upd;
        logic c1_evt;
    } trig_ev_t;

    function automatic logic ref_pick(input logic [NREF-1:0] refs,
                                      input logic [REF_W-1:0] idx);
        return refs[idx];
    endfunction

endpackage

// File: rtl/tos_cfg_reg.sv
module tos_cfg_reg
    import tos_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic                dma_upd_i,
    output tos_cfg_t            cfg_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o.mode       <= TM_SWUPD;
            cfg_o.dma_on_upd <= 1'b0;
        end else if (we_i) begin
            cfg_o.mode       <= trig_mode_e'(mode_i);
            cfg_o.dma_on_upd <= dma_upd_i;
        end
    end

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (cfg_o.mode == trig_mode_e'($past(mode_i))));

endmodule

// File: rtl/tos_trig_path.sv
module tos_trig_path
    import tos_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  trig_mode_e      mode_i,
    input  logic            ms_sync_i,
    input  trig_ev_t        ev_i,
    input  logic [NREF-1:0] oc_ref_i,
    output logic            trig_o
);

    logic slv_trig_q;
    logic slv_rst_q;
    logic slv_trig_eff;
    logic run_eff;
    logic src;

    // slave trigger resync stage, bypassed in master/slave sync
    assign slv_trig_eff = ms_sync_i ? ev_i.slv_trig : slv_trig_q;
    assign run_eff      = ev_i.run_bit | (ev_i.gated & slv_trig_eff);

    always_comb begin
        unique case (mode_i)
            TM_SWUPD: src = ev_i.sw_upd | slv_rst_q;
            TM_RUN:   src = run_eff;
            TM_UPD:   src = ev_i.upd;
            TM_C1P:   src = ev_i.c1_evt;
            default:  src = ref_pick(oc_ref_i, mode_i[REF_W-1:0]);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slv_trig_q <= 1'b0;
            slv_rst_q  <= 1'b0;
            trig_o     <= 1'b0;
        end else begin
            slv_trig_q <= ev_i.slv_trig;
            slv_rst_q  <= ev_i.slv_rst;
            trig_o     <= src;
        end
    end

    // R1
    trig_rst_chk: assert property (@(posedge clk) rst |=> !trig_o);

    // R3
    swupd_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == TM_SWUPD && ev_i.sw_upd) |=> trig_o);

    // R5
    ms_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == TM_RUN && ms_sync_i && ev_i.gated && ev_i.slv_trig) |=> trig_o);

    // R6
    upd_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == TM_UPD && ev_i.upd) |=> trig_o);

    // R7
    c1_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == TM_C1P) |=> (trig_o == $past(ev_i.c1_evt)));

    // R8
    ref_follow_chk: assert property (@(posedge clk) disable iff (rst)
        mode_i[2] |=> (trig_o == $past(oc_ref_i[mode_i[REF_W-1:0]])));

endmodule

// File: rtl/tos_dma_route.sv
module tos_dma_route
    import tos_pkg::*;
#(
    parameter int NCH = 4
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           on_upd_i,
    input  logic           upd_i,
    input  logic [NCH-1:0] cc_evt_i,
    input  logic [NCH-1:0] ack_i,
    output logic [NCH-1:0] req_o
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic set_ev;
        assign set_ev = on_upd_i ? upd_i : cc_evt_i[i];

        always_ff @(posedge clk) begin
            if (rst)              req_o[i] <= 1'b0;
            else if (set_ev)      req_o[i] <= 1'b1;
            else if (ack_i[i])    req_o[i] <= 1'b0;
        end

        // R9
        cc_src_chk: assert property (@(posedge clk) disable iff (rst)
            (!on_upd_i && cc_evt_i[i]) |=> req_o[i]);

        // R9
        upd_src_chk: assert property (@(posedge clk) disable iff (rst)
            (on_upd_i && upd_i) |=> req_o[i]);

        // R10
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            (req_o[i] && !ack_i[i]) |=> req_o[i]);
    end

    // R1
    req_rst_chk: assert property (@(posedge clk) rst |=> (req_o == '0));

endmodule

// File: rtl/tmr_trig_out_sel.sv
module tmr_trig_out_sel
    import tos_pkg::*;
#(
    parameter int NCH = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_dma_upd,
    input  logic              ms_sync,
    input  logic              sw_upd_gen,
    input  logic              slv_reset_evt,
    input  logic              run_bit,
    input  logic              slv_gated,
    input  logic              slv_trig,
    input  logic              upd_evt,
    input  logic              ch1_cc_evt,
    input  logic [3:0]        oc_ref,
    input  logic [NCH-1:0]    cc_evt,
    input  logic [NCH-1:0]    dma_ack,
    output logic              trig_out,
    output logic [NCH-1:0]    dma_req
);

    tos_cfg_t cfg_q;
    trig_ev_t ev;

    assign ev.sw_upd   = sw_upd_gen;
    assign ev.slv_rst  = slv_reset_evt;
    assign ev.run_bit  = run_bit;
    assign ev.gated    = slv_gated;
    assign ev.slv_trig = slv_trig;
    assign ev.upd      = upd_evt;
    assign ev.c1_evt   = ch1_cc_evt;

    tos_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we_i      (cfg_we),
        .mode_i    (cfg_mode),
        .dma_upd_i (cfg_dma_upd),
        .cfg_o     (cfg_q)
    );

    tos_trig_path u_trig (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (cfg_q.mode),
        .ms_sync_i (ms_sync),
        .ev_i      (ev),
        .oc_ref_i  (oc_ref),
        .trig_o    (trig_out)
    );

    tos_dma_route #(.NCH(NCH)) u_dma (
        .clk      (clk),
        .rst      (rst),
        .on_upd_i (cfg_q.dma_on_upd),
        .upd_i    (upd_evt),
        .cc_evt_i (cc_evt),
        .ack_i    (dma_ack),
        .req_o    (dma_req)
    );

endmodule

// File: tb/tmr_trig_out_sel_tb.sv
`timescale 1ns/1ps
module tmr_trig_out_sel_tb;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 0;
    logic [2:0]     cfg_mode = 0;
    logic           cfg_dma_upd = 0;
    logic           ms_sync = 0;
    logic           sw_upd_gen = 0;
    logic           slv_reset_evt = 0;
    logic           run_bit = 0;
    logic           slv_gated = 0;
    logic           slv_trig = 0;
    logic           upd_evt = 0;
    logic           ch1_cc_evt = 0;
    logic [3:0]     oc_ref = 0;
    logic [NCH-1:0] cc_evt = 0;
    logic [NCH-1:0] dma_ack = 0;
    logic           trig_out;
    logic [NCH-1:0] dma_req;

    int checks = 0;
    int failures = 0;
    bit armed = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_trig_out_sel #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_dma_upd(cfg_dma_upd), .ms_sync(ms_sync), .sw_upd_gen(sw_upd_gen),
        .slv_reset_evt(slv_reset_evt), .run_bit(run_bit), .slv_gated(slv_gated),
        .slv_trig(slv_trig), .upd_evt(upd_evt), .ch1_cc_evt(ch1_cc_evt),
        .oc_ref(oc_ref), .cc_evt(cc_evt), .dma_ack(dma_ack),
        .trig_out(trig_out), .dma_req(dma_req)
    );

    // behavioural reference model
    int    m_mode = 0;
    bit    m_dsel = 0;
    bit    e_trig = 0;
    bit    e_req [NCH];
    bit    hist_trig = 0;
    bit    hist_rst = 0;
    string t_tag = "R1";
    string d_tag = "R1";

    initial foreach (e_req[k]) e_req[k] = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_dsel = 0; e_trig = 0;
            foreach (e_req[k]) e_req[k] = 0;
            hist_trig = 0; hist_rst = 0;
            t_tag = "R1"; d_tag = "R1";
        end else begin
            case (m_mode)
                0: begin e_trig = sw_upd_gen || hist_rst; t_tag = "R3"; end
                1: begin
                    e_trig = run_bit || (slv_gated && (ms_sync ? slv_trig : hist_trig));
                    t_tag = slv_gated ? "R5" : "R4";
                end
                2: begin e_trig = upd_evt; t_tag = "R6"; end
                3: begin e_trig = ch1_cc_evt; t_tag = "R7"; end
                default: begin e_trig = oc_ref[m_mode-4]; t_tag = "R8"; end
            endcase
            d_tag = "R10";
            for (int k = 0; k < NCH; k++) begin
                if (m_dsel ? upd_evt : cc_evt[k]) begin
                    e_req[k] = 1; d_tag = "R9";
                end else if (dma_ack[k]) begin
                    e_req[k] = 0;
                end
            end
            if (cfg_we) begin m_mode = int'(cfg_mode); m_dsel = cfg_dma_upd; end
            hist_trig = slv_trig;
            hist_rst  = slv_reset_evt;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            chk(t_tag, "model trig_out", int'(trig_out), int'(e_trig));
            for (int k = 0; k < NCH; k++)
                chk(d_tag, $sformatf("model dma_req[%0d]", k), int'(dma_req[k]), int'(e_req[k]));
        end
    end

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic clear_evs();
        cfg_we = 0; sw_upd_gen = 0; slv_reset_evt = 0; upd_evt = 0;
        ch1_cc_evt = 0; cc_evt = '0; dma_ack = '0; slv_trig = 0;
    endtask

    task automatic write_cfg(input logic [2:0] md, input logic dsel);
        cfg_we = 1; cfg_mode = md; cfg_dma_upd = dsel;
        nxt(); cfg_we = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        nxt(); nxt(); nxt();
        chk("R1", "trig_out in reset", int'(trig_out), 0);
        chk("R1", "dma_req in reset", int'(dma_req), 0);
        rst = 0;
        armed = 1;

        // R1 / R3: after reset the source is the software update
        sw_upd_gen = 1; nxt(); sw_upd_gen = 0;
        chk("R3", "ug one edge later", int'(trig_out), 1);
        nxt();
        chk("R3", "ug pulse ends", int'(trig_out), 0);

        // R3: slave-caused reset appears two edges later
        slv_reset_evt = 1; nxt(); slv_reset_evt = 0;
        chk("R3", "slave reset not after one edge", int'(trig_out), 0);
        nxt();
        chk("R3", "slave reset after two edges", int'(trig_out), 1);
        nxt();

        // R2: write to mode 100 while oc_ref[0] is high
        oc_ref = 4'b0001;
        cfg_we = 1; cfg_mode = 3'b100; nxt(); cfg_we = 0;
        chk("R2", "old mode at write edge", int'(trig_out), 0);
        nxt();
        chk("R2", "new mode next edge", int'(trig_out), 1);
        oc_ref = 4'b0000; nxt();

        // R8: mode 101 follows oc_ref[1]
        write_cfg(3'b101, 0);
        oc_ref = 4'b1101; nxt();
        chk("R8", "ref2 low", int'(trig_out), 0);
        oc_ref = 4'b0010; nxt();
        chk("R8", "ref2 high", int'(trig_out), 1);
        oc_ref = 0;

        // R4 / R5: run enable and slave trigger delay
        write_cfg(3'b001, 0);
        run_bit = 1; nxt(); run_bit = 0;
        chk("R4", "run bit one edge", int'(trig_out), 1);
        slv_gated = 1; ms_sync = 0;
        slv_trig = 1; nxt(); slv_trig = 0;
        chk("R5", "ms_sync=0 no output after one edge", int'(trig_out), 0);
        nxt();
        chk("R5", "ms_sync=0 output after two edges", int'(trig_out), 1);
        nxt(); ms_sync = 1;
        slv_trig = 1; nxt(); slv_trig = 0;
        chk("R5", "ms_sync=1 output after one edge", int'(trig_out), 1);
        nxt(); slv_gated = 0; ms_sync = 0;

        // R6: update event
        write_cfg(3'b010, 0);
        upd_evt = 1; nxt(); upd_evt = 0;
        chk("R6", "update event", int'(trig_out), 1);

        // R7: back-to-back compare pulses
        write_cfg(3'b011, 0);
        ch1_cc_evt = 1; nxt(); nxt(); ch1_cc_evt = 0;
        chk("R7", "second back-to-back pulse", int'(trig_out), 1);
        nxt();
        chk("R7", "pulse ends", int'(trig_out), 0);

        // R9 / R10: channel-event routing and hold/ack
        cc_evt[2] = 1; nxt(); cc_evt[2] = 0;
        chk("R9", "cc_evt[2] raises req", int'(dma_req), 4'b0100);
        upd_evt = 1; nxt(); upd_evt = 0;
        chk("R9", "upd ignored with select 0", int'(dma_req), 4'b0100);
        nxt(); nxt();
        chk("R10", "req held without ack", int'(dma_req), 4'b0100);
        dma_ack[2] = 1; cc_evt[2] = 1; nxt(); dma_ack[2] = 0; cc_evt[2] = 0;
        chk("R10", "event wins over ack", int'(dma_req), 4'b0100);
        dma_ack[2] = 1; nxt(); dma_ack[2] = 0;
        chk("R10", "ack clears req", int'(dma_req), 0);

        // R9: update routing
        write_cfg(3'b011, 1);
        cc_evt = 4'b1111; nxt(); cc_evt = 0;
        chk("R9", "cc_evt ignored with select 1", int'(dma_req), 0);
        upd_evt = 1; nxt(); upd_evt = 0;
        chk("R9", "upd raises all reqs", int'(dma_req), 4'b1111);
        dma_ack = 4'b1111; nxt(); dma_ack = 0;

        // mixed stimulus compared against the model each cycle
        for (int n = 0; n < 4000; n++) begin
            cfg_we        = ($urandom_range(0, 15) == 0);
            cfg_mode      = 3'($urandom_range(0, 7));
            cfg_dma_upd   = 1'($urandom_range(0, 1));
            ms_sync       = (n / 500) % 2 == 1;
            sw_upd_gen    = ($urandom_range(0, 3) == 0);
            slv_reset_evt = ($urandom_range(0, 5) == 0);
            run_bit       = ($urandom_range(0, 3) == 0);
            slv_gated     = ($urandom_range(0, 1) == 0);
            slv_trig      = ($urandom_range(0, 2) == 0);
            upd_evt       = ($urandom_range(0, 4) == 0);
            ch1_cc_evt    = ($urandom_range(0, 2) == 0);
            oc_ref        = 4'($urandom_range(0, 15));
            cc_evt        = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            dma_ack       = 4'($urandom_range(0, 15));
            if (n == 3000) rst = 1;
            if (n == 3003) rst = 0;
            nxt();
        end
        clear_evs();
        nxt(); nxt();
        finish_run();
    end

endmodule